// File: doc/BRIEF.md
# Synchronous Transmit Line Formatter

This block turns a stream of message bytes into the bit stream for a synchronous serial transmit line and fills the gaps between messages. A byte source offers bytes over a valid/ready handshake, with a flag on the final byte of each message. Each byte goes out least significant bit first, one bit for each pulse of the transmit clock enable. Bytes within a message follow each other with no gap.

When a message ends, the gap fill is chosen by a mode input. In ones mode the line carries ones and the request-to-send output is low. It rises for the last fill bit before the next message, and at least 17 ones separate two messages. In SYN mode the line repeats a pair of programmable sync characters (first, then second) and request-to-send stays high. Data only begins at the end of a complete pair. A message whose next byte is not valid when needed is ended as if its last byte had been flagged.

Every bit (data, ones fill and sync characters) passes through one line encoder that gives either NRZ or NRZI. After reset the block is in a ones gap. The encoder level starts high.

Top module: `sync_tx_formatter`

## Requirements
- R1: While reset is high, and directly after it, `tx_line` is 1, `rts` equals `fill_syn`, and `in_ready` is 0.
- R2: Each accepted byte goes out LSB first, one bit per enabled clock. The first bit appears on the enabled clock after the acceptance clock, and the bytes of one message follow with no gap. A byte is accepted on a clock where `in_valid` and `in_ready` are both 1.
- R3: In ones mode (`fill_syn`=0), every gap bit is a one. `rts` is 0 for all gap bits except the last.
- R4: After a ones gap, the first data bit follows at least 17 gap ones. If a byte is already waiting, exactly 17 gap ones are sent, so after reset the first data bit is the 18th enabled bit.
- R5: In ones mode, `rts` is 1 during the last gap bit before a message and stays 1 through the last data bit of the message.
- R6: In SYN mode (`fill_syn`=1), the gap carries `syn_first` then `syn_second`, each LSB first, with `rts` at 1. If a byte is waiting, the gap is exactly one pair (16 bits).
- R7: In SYN mode, data never starts inside a pair. The length of a SYN gap is always a multiple of 16 bits.
- R8: `syn_first` equal to `syn_second` behaves exactly like two different characters.
- R9: With `nrzi_en`=0, the line is high for a one bit and low for a zero bit.
- R10: With `nrzi_en`=1, a one bit keeps the previous line level and a zero bit inverts it. Fill bits are coded the same way, so an idle ones gap keeps the line high after reset.
- R11: On a clock where `bit_en` is 0, `tx_line` and `rts` do not change and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Transmit clock enable, one line bit per high cycle |
| in_valid | input | 1 | Byte offered by the source |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Offered byte closes its message |
| in_ready | output | 1 | Byte is taken at this clock if valid |
| syn_first | input | 8 | First sync character of the fill pair |
| syn_second | input | 8 | Second sync character of the fill pair |
| fill_syn | input | 1 | Gap fill: 0 ones with RTS low, 1 sync pairs with RTS high |
| nrzi_en | input | 1 | Line code: 0 NRZ, 1 NRZI |
| tx_line | output | 1 | Encoded serial data |
| rts | output | 1 | Request to send |

## Verification
The bench checks the exact length of the gap between two back-to-back messages. A design that counted ones off by one would give 16 or 18 ones, not 17. A design that cut a sync pair short would give a SYN gap that is not a multiple of 16. It checks the request-to-send edge bit by bit, so a version that raised it on the first data bit or dropped it during the last data bit fails. It also runs equal sync characters, NRZI coding of fill and data, and a gated enable. A design that ignored the enable, or decided its index on the character value rather than its position, would lose or repeat bits there.

// File: rtl/stxf_pkg.sv
package stxf_pkg;

    localparam int STXF_BYTE_W   = 8;
    localparam int STXF_MIN_ONES = 17;
    localparam int STXF_BIT_IW   = $clog2(STXF_BYTE_W);

    typedef enum logic [1:0] {
        ST_ONES = 2'd0,
        ST_SYN  = 2'd1,
        ST_DATA = 2'd2
    } stxf_state_e;

    typedef struct packed {
        logic                   last;
        logic [STXF_BYTE_W-1:0] data;
    } stxf_slot_t;

endpackage

// File: rtl/stxf_gap_count.sv
module stxf_gap_count #(
    parameter int MIN_ONES = stxf_pkg::STXF_MIN_ONES
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic counting,
    input  logic clear,
    output logic enough
);
    localparam int CW = $clog2(MIN_ONES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (bit_en && counting && (cnt != CW'(MIN_ONES))) begin
            cnt <= cnt + 1'b1;
        end
    end

    // the bit going out this tick is the last one needed
    assign enough = (cnt >= CW'(MIN_ONES - 1));

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MIN_ONES)); // R4

endmodule

// File: rtl/stxf_line_enc.sv
module stxf_line_enc (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic nrzi,
    input  logic raw,
    output logic line
);
    always_ff @(posedge clk) begin
        if (rst) begin
            line <= 1'b1;
        end else if (bit_en) begin
            if (nrzi) begin
                line <= raw ? line : ~line;
            end else begin
                line <= raw;
            end
        end
    end

    AST_NRZ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !nrzi) |=> (line == $past(raw))); // R9
    AST_NRZI_ONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bit_en && nrzi && raw) |=> $stable(line)); // R10
    AST_NRZI_ZERO_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (bit_en && nrzi && !raw) |=> (line != $past(line))); // R10
    AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line)); // R11

endmodule

// File: rtl/stxf_seq.sv
module stxf_seq
    import stxf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bit_en,
    input  logic                   fill_syn,
    input  logic                   in_valid,
    input  logic [STXF_BYTE_W-1:0] in_data,
    input  logic                   in_last,
    output logic                   in_ready,
    input  logic [STXF_BYTE_W-1:0] syn_first,
    input  logic [STXF_BYTE_W-1:0] syn_second,
    input  logic                   enough,
    output logic                   counting,
    output logic                   cnt_clear,
    output logic                   raw,
    output logic                   rts_q
);
    stxf_state_e            state;
    stxf_slot_t             slot;
    stxf_slot_t             incoming;
    logic [STXF_BIT_IW-1:0] bitcnt;
    logic                   sidx;
    logic                   bit_last;
    logic                   want;
    logic                   take;
    logic [STXF_BYTE_W-1:0] syn_char;

    assign bit_last = (bitcnt == STXF_BIT_IW'(STXF_BYTE_W - 1));
    assign syn_char = sidx ? syn_second : syn_first;
    assign incoming = '{last: in_last, data: in_data};

    always_comb begin
        unique case (state)
            ST_ONES: want = enough;
            ST_SYN:  want = sidx && bit_last;
            ST_DATA: want = bit_last && !slot.last;
            default: want = 1'b0;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_SYN:  raw = syn_char[bitcnt];
            ST_DATA: raw = slot.data[bitcnt];
            default: raw = 1'b1;
        endcase
    end

    assign in_ready  = bit_en && want;
    assign take      = in_ready && in_valid;
    assign counting  = (state == ST_ONES);
    assign cnt_clear = bit_en && (state == ST_DATA) && bit_last && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_ONES;
            slot   <= '0;
            bitcnt <= '0;
            sidx   <= 1'b0;
            rts_q  <= 1'b0;
        end else if (bit_en) begin
            unique case (state)
                ST_ONES: begin
                    rts_q <= take;
                    if (take) begin
                        state  <= ST_DATA;
                        slot   <= incoming;
                        bitcnt <= '0;
                    end
                end
                ST_SYN: begin
                    rts_q  <= take;
                    bitcnt <= bit_last ? '0 : bitcnt + 1'b1;
                    if (bit_last) begin
                        if (take) begin
                            state <= ST_DATA;
                            slot  <= incoming;
                        end else begin
                            sidx <= ~sidx;
                        end
                    end
                end
                ST_DATA: begin
                    bitcnt <= bit_last ? '0 : bitcnt + 1'b1;
                    if (bit_last) begin
                        if (take) begin
                            slot <= incoming;
                        end else if (fill_syn) begin
                            state <= ST_SYN;
                            sidx  <= 1'b0;
                        end else begin
                            state <= ST_ONES;
                        end
                    end
                end
                default: state <= ST_ONES;
            endcase
        end
    end

    AST_ONES_HOLD_UNTIL_ENOUGH: assert property (@(posedge clk) disable iff (rst)
        (bit_en && state == ST_ONES && !enough) |=> (state == ST_ONES)); // R4
    AST_RTS_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> rts_q); // R5
    AST_SYN_PAIR_WHOLE: assert property (@(posedge clk) disable iff (rst)
        (bit_en && state == ST_SYN && !(sidx && bit_last)) |=> (state == ST_SYN)); // R7
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(state) && $stable(bitcnt) && $stable(rts_q))); // R11

endmodule

// File: rtl/sync_tx_formatter.sv
module sync_tx_formatter #(
    parameter int MIN_ONES = stxf_pkg::STXF_MIN_ONES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    input  logic [7:0] syn_first,
    input  logic [7:0] syn_second,
    input  logic       fill_syn,
    input  logic       nrzi_en,
    output logic       tx_line,
    output logic       rts
);
    logic enough;
    logic counting;
    logic cnt_clear;
    logic raw;
    logic rts_q;

    stxf_seq i_seq (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .fill_syn   (fill_syn),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .syn_first  (syn_first),
        .syn_second (syn_second),
        .enough     (enough),
        .counting   (counting),
        .cnt_clear  (cnt_clear),
        .raw        (raw),
        .rts_q      (rts_q)
    );

    stxf_gap_count #(.MIN_ONES(MIN_ONES)) i_gap (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .counting (counting),
        .clear    (cnt_clear),
        .enough   (enough)
    );

    stxf_line_enc i_enc (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .nrzi   (nrzi_en),
        .raw    (raw),
        .line   (tx_line)
    );

    assign rts = fill_syn | rts_q;

    AST_READY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> bit_en); // R11

endmodule

// File: tb/test_sync_tx_formatter.sv
module test_sync_tx_formatter;

    typedef struct packed {
        logic       fill;
        logic       nrzi;
        logic [1:0] nb;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] sa;
        logic [7:0] sb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd2, 8'hA5, 8'h3C, 8'h16, 8'h16},
        '{1'b0, 1'b1, 2'd1, 8'h00, 8'h00, 8'h16, 8'h16},
        '{1'b1, 1'b0, 2'd2, 8'hF0, 8'h0F, 8'h32, 8'h54},
        '{1'b1, 1'b1, 2'd2, 8'h81, 8'h7E, 8'h32, 8'h54},
        '{1'b1, 1'b0, 2'd1, 8'hC3, 8'h00, 8'h16, 8'h16},
        '{1'b1, 1'b1, 2'd2, 8'hFF, 8'h00, 8'hAA, 8'hAA},
        '{1'b0, 1'b1, 2'd2, 8'h55, 8'hAA, 8'h16, 8'h16},
        '{1'b0, 1'b0, 2'd1, 8'h01, 8'h00, 8'h16, 8'h16}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic [7:0] syn_first = 8'h16;
    logic [7:0] syn_second = 8'h16;
    logic       fill_syn = 1'b0;
    logic       nrzi_en = 1'b1;
    logic       in_ready;
    logic       tx_line;
    logic       rts;

    int  total = 0;
    int  bad = 0;
    bit  rec_bit [16384];
    bit  rec_rts [16384];
    int  nrec = 0;
    bit  mon_on = 1'b0;
    bit  slow = 1'b0;
    int  ph = 0;
    logic prev_line = 1'b1;
    logic prev_rts = 1'b0;

    sync_tx_formatter i_sync_tx_formatter (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .syn_first  (syn_first),
        .syn_second (syn_second),
        .fill_syn   (fill_syn),
        .nrzi_en    (nrzi_en),
        .tx_line    (tx_line),
        .rts        (rts)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: one record per enabled edge, decoded by the current line code
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                if (bit_en) begin
                    rec_bit[nrec] = nrzi_en ? (tx_line == prev_line) : tx_line;
                    rec_rts[nrec] = rts;
                    nrec++;
                end else begin
                    chk(tx_line == prev_line && rts == prev_rts, "R11 frozen line/rts",
                        int'({tx_line, rts}), int'({prev_line, prev_rts}));
                end
                prev_line = tx_line;
                prev_rts  = rts;
            end
        end
    end

    task automatic step();
        @(negedge clk);
        bit_en = slow ? (ph == 0) : 1'b1;
        ph = (ph + 1) % 3;
        #1;
        if (slow && !bit_en) chk(!in_ready, "R11 ready while disabled", int'(in_ready), 0);
    endtask

    task automatic wait_ready();
        while (!in_ready) step();
    endtask

    task automatic send_msg(input int nb, input logic [7:0] b0, input logic [7:0] b1,
                            output int start);
        in_valid = 1'b1;
        in_data  = b0;
        in_last  = (nb == 1);
        wait_ready();
        start = nrec + 1;
        if (nb > 1) begin
            step();
            in_data = b1;
            in_last = 1'b1;
            wait_ready();
        end
        step();
        in_valid = 1'b0;
    endtask

    task automatic wait_recs(input int upto);
        while (nrec < upto) step();
    endtask

    task automatic chk_msg(input int start, input int nb, input logic [7:0] b0,
                           input logic [7:0] b1, input string req);
        int rts_errs = 0;
        for (int b = 0; b < nb; b++) begin
            logic [7:0] got;
            logic [7:0] exp;
            exp = (b == 0) ? b0 : b1;
            for (int i = 0; i < 8; i++) begin
                got[i] = rec_bit[start + 8*b + i];
                if (!rec_rts[start + 8*b + i]) rts_errs++;
            end
            chk(got == exp, req, int'(got), int'(exp));
        end
        chk(rts_errs == 0, "R5 rts during data", rts_errs, 0);
    endtask

    task automatic chk_gap(input int from, input int len, input bit fill,
                           input logic [7:0] sa, input logic [7:0] sb, input string req);
        int errs = 0;
        for (int i = 0; i < len; i++) begin
            if (fill) begin
                logic e;
                e = ((i % 16) < 8) ? sa[i % 8] : sb[i % 8];
                if (rec_bit[from + i] != e) errs++;
                if (!rec_rts[from + i]) errs++;
            end else begin
                if (!rec_bit[from + i]) errs++;
                if (rec_rts[from + i] != (i == len - 1)) errs++;
            end
        end
        chk(errs == 0 && len > 0, req, errs, 0);
        if (fill) chk((len % 16) == 0, "R7 gap multiple of pair", len % 16, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int sa_;
        int sb_;
        bit_en = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(tx_line == 1'b1, "R1 line in reset", int'(tx_line), 1);
        chk(rts == 1'b0, "R1 rts in reset", int'(rts), 0);
        chk(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
        rst = 1'b0;
        prev_line = tx_line;
        prev_rts  = rts;
        mon_on = 1'b1;

        // R4 R10: first message after reset, NRZI ones gap keeps line high
        send_msg(1, 8'h96, 8'h00, sa_);
        chk(tx_line == 1'b1, "R10 idle NRZI level high", int'(tx_line), 1);
        chk(sa_ == 17, "R4 first data bit index after reset", sa_, 17);
        wait_recs(sa_ + 9);
        chk_gap(0, 17, 1'b0, 8'h00, 8'h00, "R3 R5 initial ones gap");
        chk_msg(sa_, 1, 8'h96, 8'h00, "R2 R10 first message");

        // vector table: message A, then message B back to back
        for (int v = 0; v < NV; v++) begin
            int sA;
            int sB;
            int glen;
            string dreq;
            fill_syn   = VECS[v].fill;
            nrzi_en    = VECS[v].nrzi;
            syn_first  = VECS[v].sa;
            syn_second = VECS[v].sb;
            send_msg(int'(VECS[v].nb), VECS[v].b0, VECS[v].b1, sA);
            send_msg(int'(VECS[v].nb), ~VECS[v].b1, ~VECS[v].b0, sB);
            wait_recs(sB + 8*int'(VECS[v].nb) + 1);
            dreq = VECS[v].nrzi ? "R2 R10 data" : "R2 R9 data";
            chk_msg(sA, int'(VECS[v].nb), VECS[v].b0, VECS[v].b1, dreq);
            chk_msg(sB, int'(VECS[v].nb), ~VECS[v].b1, ~VECS[v].b0, dreq);
            glen = sB - (sA + 8*int'(VECS[v].nb));
            if (VECS[v].fill) begin
                chk(glen == 16, "R6 pair gap length", glen, 16);
                chk_gap(sA + 8*int'(VECS[v].nb), glen, 1'b1, VECS[v].sa, VECS[v].sb,
                        (VECS[v].sa == VECS[v].sb) ? "R8 equal sync pair" : "R6 sync pair content");
            end else begin
                chk(glen == 17, "R4 ones gap length", glen, 17);
                chk_gap(sA + 8*int'(VECS[v].nb), glen, 1'b0, 8'h00, 8'h00, "R3 R5 ones gap");
            end
        end

        // long ones gap: all ones, rts rises only on the last gap bit
        begin
            int sA;
            int sB;
            int glen;
            fill_syn = 1'b0;
            nrzi_en  = 1'b0;
            send_msg(1, 8'h3A, 8'h00, sA);
            repeat (40) step();
            send_msg(1, 8'hC5, 8'h00, sB);
            wait_recs(sB + 9);
            glen = sB - (sA + 8);
            chk(glen >= 17, "R4 long ones gap", glen, 17);
            chk_gap(sA + 8, glen, 1'b0, 8'h00, 8'h00, "R3 R5 long ones gap");
            chk_msg(sB, 1, 8'hC5, 8'h00, "R2 R9 after long gap");
        end

        // delayed data in sync mode: whole pairs only
        begin
            int sA;
            int sB;
            fill_syn   = 1'b1;
            nrzi_en    = 1'b1;
            syn_first  = 8'h4B;
            syn_second = 8'hD2;
            send_msg(1, 8'h5A, 8'h00, sA);
            repeat (27) step();
            send_msg(1, 8'hE1, 8'h00, sB);
            wait_recs(sB + 9);
            chk(sB - (sA + 8) >= 32, "R7 delayed gap spans pairs", sB - (sA + 8), 32);
            chk_gap(sA + 8, sB - (sA + 8), 1'b1, 8'h4B, 8'hD2, "R7 delayed sync gap");
            chk_msg(sB, 1, 8'hE1, 8'h00, "R7 data after pairs");
        end

        // gated enable: one bit every third clock
        begin
            int sA;
            slow = 1'b1;
            send_msg(2, 8'h6D, 8'hB2, sA);
            wait_recs(sA + 17);
            chk_msg(sA, 2, 8'h6D, 8'hB2, "R11 R2 gated enable");
            slow = 1'b0;
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule